// File: doc/BRIEF.md
# GPIO edge interrupt controller

This block watches eighteen debounced pin levels and turns qualifying transitions into latched per-pin interrupt status and a single interrupt request. A pin takes part only while it is configured as an input and its interrupt enable is set. A per-pin select chooses whether a rising or a falling transition counts. Once a pin has latched, the latch drops in two cases: the pin goes back to the level it had just before the transition, or the host reads the status bank that holds it. A global flag records that at least one latch was taken. It stays set until the host writes a value with its clear bit set.

The serial bus front end is outside this block. The front end gives a one-cycle strobe at the acknowledge (or not-acknowledge) bit of a status-bank read, along with the bank number. It also gives a one-cycle strobe with the data byte of a write to the global register. The request output is an output enable for an active-low open-drain pad: 1 pulls the line low.

Each pin runs a two-state machine:
- PIN_QUIET moves to PIN_PENDING on a qualified transition (transition "latch").
- PIN_PENDING moves back to PIN_QUIET on a bank read (transition "read-clear") or when the level returns to its pre-transition value (transition "return-clear").
- A qualified transition that coincides with a read of its own bank keeps the pin in PIN_QUIET (transition "lost").

The global flag runs a two-state machine:
- GF_CLEAR moves to GF_RAISED on any latch (transition "raise").
- GF_RAISED moves back to GF_CLEAR on a clearing write with no latch in the same cycle (transition "drop").

Top module: `gpio_irq_ctrl`

## Requirements
- R1: A pin whose `pin_is_out` bit is 1, or whose `irq_enable` bit is 0, never sets its status bit.
- R2: For an enabled input, `rise_sel`=1 latches on a 0-to-1 level change and `rise_sel`=0 latches on a 1-to-0 change. The opposite change does not latch. The status bit is visible one clock after the new level is sampled.
- R3: A latched pin whose input level returns to the level it had before the latching transition clears its status bit one clock later.
- R4: A pulse on `stat_rd_ack` with `stat_rd_bank`=b clears the status of pins 8b to 8b+7 one clock later (bank 2 holds pins 16 and 17). Status bits in the other banks are left unchanged. A later qualified transition latches again.
- R5: `gflag` becomes 1 one clock after any latch. It returns to 0 only after a `gflag_wr` pulse whose `gflag_wdata` bit 1 is set. A write with bit 1 clear leaves it at 1.
- R6: `irq_oe` is 1 exactly when `gflag` is 1 or a status bit is 1 with its `irq_enable` bit also 1.
- R7: A pin keeps the level it had when it was last an input. On a switch from output to input, a different current level counts as a transition, and it latches if the direction matches `rise_sel`.
- R8: A qualified transition in the same cycle as a read of its own bank is lost: no status bit and no `gflag` raise. A latch in the same cycle as a clearing write leaves `gflag` at 1.
- R9: After reset, all status bits, `gflag` and `irq_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_level | input | 18 | Debounced pin levels |
| pin_is_out | input | 18 | 1 = pin is an output |
| irq_enable | input | 18 | Per-pin interrupt enable |
| rise_sel | input | 18 | 1 = rising transition, 0 = falling transition |
| stat_rd_ack | input | 1 | Strobe at the ack/nack bit of a status-bank read |
| stat_rd_bank | input | 2 | Bank read: 0 = pins 0-7, 1 = pins 8-15, 2 = pins 16-17 |
| gflag_wr | input | 1 | Strobe for a write to the global register |
| gflag_wdata | input | 8 | Write data; bit 1 set clears the flag |
| pin_status | output | 18 | Latched per-pin interrupt status |
| gflag | output | 1 | Global interrupt flag |
| irq_oe | output | 1 | Pull-down enable for the open-drain request |

## Verification
Two pairs of functions can fall in the same cycle here.

The first pair is a read-clear and a new qualified transition on a pin of the bank being read. The bench raises pin 2 in the same cycle as the bank-0 read strobe. It then expects the status bit, the flag and the request to stay at 0, because the transition is lost.

The second pair is a new latch on one pin and a clearing write to the global register. The bench raises pin 9 together with a write of 0x02. It expects the flag to remain 1.

A full sweep over every pin and every combination of direction, enable and edge select checks latch, return-clear and isolation from the other pins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    typedef enum logic {
        PIN_QUIET   = 1'b0,
        PIN_PENDING = 1'b1
    } pin_st_t;

    typedef enum logic {
        GF_CLEAR  = 1'b0,
        GF_RAISED = 1'b1
    } gf_st_t;
endpackage

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic is_out,
    input  logic en,
    input  logic rise,
    input  logic clr,
    output logic pending,
    output logic hit
);
    pin_st_t st, st_nx;
    logic    last_in_lvl;
    logic    orig_lvl;
    logic    qual_edge;
    logic    back_home;

    assign qual_edge = !is_out && en && (lvl != last_in_lvl) && (lvl == rise);
    assign back_home = !is_out && (lvl == orig_lvl);

    always_comb begin
        st_nx = st;
        unique case (st)
            PIN_QUIET:   if (qual_edge && !clr) st_nx = PIN_PENDING;
            PIN_PENDING: if (clr || back_home)  st_nx = PIN_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st          <= PIN_QUIET;
            last_in_lvl <= 1'b0;
            orig_lvl    <= 1'b0;
        end else begin
            st <= st_nx;
            if (!is_out) last_in_lvl <= lvl;
            if (hit)     orig_lvl    <= last_in_lvl;
        end
    end

    always_comb begin
        pending = (st == PIN_PENDING);
        hit     = (st == PIN_QUIET) && (st_nx == PIN_PENDING);
    end

    // R1: blocked pins stay quiet
    a_r1_blocked_stays_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PIN_QUIET && (is_out || !en)) |=> (st == PIN_QUIET));

    // R2: a new latch matches the selected polarity
    a_r2_edge_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> ($past(lvl) == $past(rise)));

    // R4: read strobe empties the latch
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pending);
endmodule

// File: rtl/gpio_irq_gflag.sv
module gpio_irq_gflag
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_hit,
    input  logic clr_req,
    output logic flag
);
    gf_st_t st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            GF_CLEAR:  if (any_hit)             st_nx = GF_RAISED;
            GF_RAISED: if (clr_req && !any_hit) st_nx = GF_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= GF_CLEAR;
        else        st <= st_nx;
    end

    always_comb flag = (st == GF_RAISED);

    // R5: the flag drops only after a clearing write
    a_r5_drop_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr_req));

    // R8: a latch always leaves the flag raised, even with a clearing write
    a_r8_hit_raises: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |=> flag);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
    parameter int NPINS    = 18,
    parameter int BANK_W   = 8,
    parameter int GCLR_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_level,
    input  logic [NPINS-1:0] pin_is_out,
    input  logic [NPINS-1:0] irq_enable,
    input  logic [NPINS-1:0] rise_sel,
    input  logic             stat_rd_ack,
    input  logic [1:0]       stat_rd_bank,
    input  logic             gflag_wr,
    input  logic [7:0]       gflag_wdata,
    output logic [NPINS-1:0] pin_status,
    output logic             gflag,
    output logic             irq_oe
);
    localparam int NBANKS  = (NPINS + BANK_W - 1) / BANK_W;
    localparam int BANK_IW = (NBANKS > 1) ? $clog2(NBANKS) : 1;

    logic [NPINS-1:0] hits;
    logic             clr_req;

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            localparam logic [1:0] MY_BANK = 2'(i / BANK_W);
            logic bank_clr;
            assign bank_clr = stat_rd_ack && (stat_rd_bank == MY_BANK);
            gpio_irq_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .lvl     (pin_level[i]),
                .is_out  (pin_is_out[i]),
                .en      (irq_enable[i]),
                .rise    (rise_sel[i]),
                .clr     (bank_clr),
                .pending (pin_status[i]),
                .hit     (hits[i])
            );
        end
    endgenerate

    assign clr_req = gflag_wr && gflag_wdata[GCLR_BIT];

    gpio_irq_gflag u_gflag (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_hit (|hits),
        .clr_req (clr_req),
        .flag    (gflag)
    );

    assign irq_oe = gflag || (|(pin_status & irq_enable));

    // R9: request stays released until something latches
    a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!gflag) && !gflag && pin_status == '0) |-> !irq_oe);

    initial begin
        a_r4_bank_index_fits: assert (BANK_IW <= 2);
    end
endmodule

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/100ps
module gpio_irq_ctrl_test;
    localparam int N = 18;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] pin_level, pin_is_out, irq_enable, rise_sel;
    logic         stat_rd_ack;
    logic [1:0]   stat_rd_bank;
    logic         gflag_wr;
    logic [7:0]   gflag_wdata;
    logic [N-1:0] pin_status;
    logic         gflag, irq_oe;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .pin_is_out(pin_is_out),
        .irq_enable(irq_enable), .rise_sel(rise_sel), .stat_rd_ack(stat_rd_ack),
        .stat_rd_bank(stat_rd_bank), .gflag_wr(gflag_wr), .gflag_wdata(gflag_wdata),
        .pin_status(pin_status), .gflag(gflag), .irq_oe(irq_oe)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic clean_all;
        for (int b = 0; b < 3; b++) begin
            stat_rd_ack  = 1'b1;
            stat_rd_bank = 2'(b);
            tick();
        end
        stat_rd_ack = 1'b0;
        gflag_wr    = 1'b1;
        gflag_wdata = 8'h02;
        tick();
        gflag_wr    = 1'b0;
        gflag_wdata = 8'h00;
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog: got hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        pin_level = '0; pin_is_out = '0; irq_enable = '0; rise_sel = '0;
        stat_rd_ack = 1'b0; stat_rd_bank = 2'd0; gflag_wr = 1'b0; gflag_wdata = 8'h00;
        tick(); tick();
        chk("R9 status", pin_status, '0);
        chk("R9 gflag", N'(gflag), '0);
        chk("R9 irq_oe", N'(irq_oe), '0);
        rst_n = 1'b1;
        tick();
        chk("R9 status after release", pin_status, '0);

        // Sweep: every pin, every direction/enable/polarity combination (R1 R2 R3)
        for (int i = 0; i < N; i++) begin
            for (int c = 0; c < 8; c++) begin
                logic o, e, r, exp1, exp2;
                o = c[0]; e = c[1]; r = c[2];
                pin_level = '0; pin_is_out = '0; irq_enable = '0; rise_sel = '0;
                tick();
                clean_all();
                pin_is_out[i] = o; irq_enable[i] = e; rise_sel[i] = r;
                tick();
                exp1 = !o && e && r;
                exp2 = !o && e && !r;
                pin_level[i] = 1'b1;
                tick();
                chk("R1/R2 rising latch", N'(pin_status[i]), N'(exp1));
                chk("R5 flag after rising", N'(gflag), N'(exp1));
                chk("R6 irq_oe after rising", N'(irq_oe), N'(exp1));
                chk("R1 other pins quiet", pin_status & ~(N'(1) << i), '0);
                pin_level[i] = 1'b0;
                tick();
                chk("R2/R3 falling latch or return-clear", N'(pin_status[i]), N'(exp2));
                chk("R5 flag after falling", N'(gflag), N'(exp1 || exp2));
            end
        end

        // R4: bank-selective read clear
        pin_level = '0; pin_is_out = '0; irq_enable = '1; rise_sel = '1;
        tick();
        clean_all();
        pin_level[3] = 1'b1; pin_level[10] = 1'b1; pin_level[17] = 1'b1;
        tick();
        chk("R4 three latched", pin_status, N'(18'h20408));
        stat_rd_ack = 1'b1; stat_rd_bank = 2'd1;
        tick();
        stat_rd_ack = 1'b0;
        chk("R4 bank1 read clears pin10 only", pin_status, N'(18'h20008));
        stat_rd_ack = 1'b1; stat_rd_bank = 2'd2;
        tick();
        stat_rd_ack = 1'b0;
        chk("R4 bank2 read clears pin17", pin_status, N'(18'h00008));
        stat_rd_ack = 1'b1; stat_rd_bank = 2'd0;
        tick();
        stat_rd_ack = 1'b0;
        chk("R4 bank0 read clears pin3", pin_status, '0);
        pin_level[3] = 1'b0;
        tick();
        pin_level[3] = 1'b1;
        tick();
        chk("R4 new change latches again", pin_status, N'(18'h00008));

        // R5: only a write with bit 1 clears the flag
        gflag_wr = 1'b1; gflag_wdata = 8'h00;
        tick();
        chk("R5 write 0x00 ignored", N'(gflag), N'(1));
        gflag_wdata = 8'hFD;
        tick();
        chk("R5 write 0xFD ignored", N'(gflag), N'(1));
        gflag_wdata = 8'h02;
        tick();
        gflag_wr = 1'b0;
        chk("R5 write 0x02 clears", N'(gflag), N'(0));
        chk("R6 oe held by enabled status", N'(irq_oe), N'(1));
        irq_enable[3] = 1'b0;
        #0.5;
        chk("R6 oe released when masked", N'(irq_oe), N'(0));
        irq_enable[3] = 1'b1;
        #0.5;
        chk("R6 oe back when unmasked", N'(irq_oe), N'(1));

        // R7: output-to-input switch with different level
        pin_level = '0; pin_is_out = '0; irq_enable = '1; rise_sel = '1;
        tick();
        clean_all();
        pin_is_out[5] = 1'b1;
        tick();
        pin_level[5] = 1'b1;
        tick();
        chk("R7 no latch while output", pin_status, '0);
        pin_is_out[5] = 1'b0;
        tick();
        chk("R7 spurious latch on switch", pin_status, N'(18'h00020));

        // R8: lost edge on coinciding read; flag kept on coinciding write
        pin_level = '0; pin_is_out = '0; irq_enable = '1; rise_sel = '1;
        tick();
        clean_all();
        pin_level[2] = 1'b1; stat_rd_ack = 1'b1; stat_rd_bank = 2'd0;
        tick();
        stat_rd_ack = 1'b0;
        chk("R8 edge lost during read", pin_status, '0);
        chk("R8 flag not raised by lost edge", N'(gflag), N'(0));
        chk("R8 request idle after lost edge", N'(irq_oe), N'(0));
        pin_level[12] = 1'b1;
        tick();
        chk("R8 pin12 raises flag", N'(gflag), N'(1));
        pin_level[9] = 1'b1; gflag_wr = 1'b1; gflag_wdata = 8'h02;
        tick();
        gflag_wr = 1'b0;
        chk("R8 flag kept on coinciding write", N'(gflag), N'(1));
        chk("R8 pin9 latched", pin_status, N'(18'h01200));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule